// File: doc/BRIEF.md
# Multi-Threshold Trigger Primitive Encoder

This block turns per-channel detector samples into compact trigger primitives, one set per beam crossing. Every link clock it takes one 12-bit sample for each of 24 channels. It tracks the largest sample of each channel over the current crossing. When the crossing strobe arrives, it grades each channel's peak against seven programmable levels. The grade is a 3-bit code: the number of levels that the peak strictly exceeds.

The link clock runs at six times the crossing rate, and the output is a 12-bit word that holds four codes. After each strobe the block therefore sends a frame of six words, which carries all 24 codes within one crossing. A valid flag marks each word and a start flag marks the first word of each frame. The codes sent in a frame stay frozen while the peaks of the next crossing build up. A simple write port loads the seven levels, which must be loaded in ascending order. After reset every level is at full scale, so every code is zero until software loads the levels.

Top module: `trip_encoder`

## Requirements
- R1: Reset sets all seven levels to 12'hFFF, clears the peaks and the latched codes, and leaves link_valid_o and frame_start_o low with link_word_o at zero. Until the levels are written, every code sent is 0, even for samples of 12'hFFF.
- R2: A channel's code is the count of levels that its peak strictly exceeds (peak > level), from 0 to 7. A peak equal to a level does not count that level.
- R3: The peak of a crossing is the maximum of the samples taken from the cycle in which xing_i is high up to the cycle before the next xing_i. The sample taken in a strobe cycle belongs to the new crossing.
- R4: On a clock edge where xing_i is high, the codes of the crossing that ends are latched. Word 0 appears in the cycle after that edge, with frame_start_o high.
- R5: Word k (k = 0..5) carries channels 4k..4k+3. Channel 4k is in bits [2:0], 4k+1 in [5:3], 4k+2 in [8:6] and 4k+3 in [11:9].
- R6: After a strobe, link_valid_o is high for six consecutive cycles carrying words 0 to 5. It then goes low unless another strobe has come. frame_start_o is high only with word 0, and link_word_o is zero whenever link_valid_o is low.
- R7: The latched codes change only on a strobe edge. A frame's words are not affected by the samples taken while it is being sent.
- R8: A strobe that arrives before word 5 has been sent restarts the frame at word 0 with the newly latched codes.
- R9: A write with thr_we_i high and thr_idx_i from 0 to 6 loads thr_val_i into that level from the next edge on. A strobe in the same cycle still grades against the old value. A write with thr_idx_i = 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, six times the crossing rate |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_i | input | 1 | One-cycle crossing strobe |
| sample_i | input | 288 | Samples, channel c in bits [12c+11:12c] |
| thr_we_i | input | 1 | Level write enable |
| thr_idx_i | input | 3 | Level index to write |
| thr_val_i | input | 12 | Level value to write |
| link_word_o | output | 12 | Four packed 3-bit codes |
| link_valid_o | output | 1 | Word is valid |
| frame_start_o | output | 1 | Word is word 0 of a frame |

## Verification
A strobe taken at edge E puts word k on the link in the cycle after edge E+k. The codes in that frame use the peaks gathered before E and the levels as they stood before E. Level writes count from the edge that follows the write cycle. The bench drives its inputs at the falling edge and keeps its own model of the peaks, levels and frame position. It advances that model once for each rising edge and compares valid, start and word at the next falling edge, so every comparison lands in the cycle where the result is due.

// File: rtl/trip_pkg.sv
package trip_pkg;
  function automatic int unsigned count_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/trip_thr_bank.sv
module trip_thr_bank #(
  parameter int NUM_THR  = 7,
  parameter int SAMPLE_W = 12,
  parameter int IDX_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [SAMPLE_W-1:0]          val_i,
  output logic [NUM_THR*SAMPLE_W-1:0]  thr_flat_o
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_lvl
    logic [SAMPLE_W-1:0] lvl_q;
    logic                hit;
    assign hit = we_i && (int'(idx_i) == t);
    always_ff @(posedge clk) begin
      if (!rst_n)   lvl_q <= '1;
      else if (hit) lvl_q <= val_i;
    end
    assign thr_flat_o[t*SAMPLE_W +: SAMPLE_W] = lvl_q;
  end
endmodule

// File: rtl/trip_peak_hold.sv
module trip_peak_hold #(
  parameter int NUM_CH   = 24,
  parameter int SAMPLE_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        xing_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]  sample_i,
  output logic [NUM_CH*SAMPLE_W-1:0]  peak_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] pk_q;
    logic [SAMPLE_W-1:0] s;
    assign s = sample_i[c*SAMPLE_W +: SAMPLE_W];
    always_ff @(posedge clk) begin
      if (!rst_n)        pk_q <= '0;
      else if (xing_i)   pk_q <= s;
      else if (s > pk_q) pk_q <= s;
    end
    assign peak_o[c*SAMPLE_W +: SAMPLE_W] = pk_q;
  end
endmodule

// File: rtl/trip_code_latch.sv
module trip_code_latch #(
  parameter int NUM_CH   = 24,
  parameter int NUM_THR  = 7,
  parameter int SAMPLE_W = 12,
  parameter int CODE_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        xing_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]  peak_i,
  input  logic [NUM_THR*SAMPLE_W-1:0] thr_i,
  output logic [NUM_CH*CODE_W-1:0]    codes_o
);
  import trip_pkg::*;
  logic [NUM_CH*CODE_W-1:0] codes_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] pk;
    logic [31:0]         above;
    logic [CODE_W-1:0]   grade;
    assign pk = peak_i[c*SAMPLE_W +: SAMPLE_W];
    always_comb begin
      above = '0;
      for (int t = 0; t < NUM_THR; t++)
        above[t] = pk > thr_i[t*SAMPLE_W +: SAMPLE_W];
    end
    assign grade = CODE_W'(count_ones(above));
    always_ff @(posedge clk) begin
      if (!rst_n)      codes_q[c*CODE_W +: CODE_W] <= '0;
      else if (xing_i) codes_q[c*CODE_W +: CODE_W] <= grade;
    end
  end
  assign codes_o = codes_q;
endmodule

// File: rtl/trip_word_framer.sv
module trip_word_framer #(
  parameter int NUM_CH      = 24,
  parameter int CODE_W      = 3,
  parameter int CH_PER_WORD = 4,
  localparam int WORDS      = NUM_CH / CH_PER_WORD,
  localparam int WORD_W     = CH_PER_WORD * CODE_W,
  localparam int WIDX_W     = $clog2(WORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xing_i,
  input  logic [NUM_CH*CODE_W-1:0] codes_i,
  output logic [WORD_W-1:0]        word_o,
  output logic                     valid_o,
  output logic                     start_o,
  output logic [WIDX_W-1:0]        idx_o
);
  logic [WIDX_W-1:0] cnt_q;
  logic              act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (xing_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (int'(cnt_q) == WORDS - 1) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_o  = act_q ? codes_i[int'(cnt_q)*WORD_W +: WORD_W] : '0;
  assign valid_o = act_q;
  assign start_o = act_q && (cnt_q == '0);
  assign idx_o   = cnt_q;
endmodule

// File: rtl/trip_encoder.sv
module trip_encoder #(
  parameter int NUM_CH      = 24,
  parameter int NUM_THR     = 7,
  parameter int SAMPLE_W    = 12,
  parameter int CH_PER_WORD = 4,
  localparam int CODE_W     = $clog2(NUM_THR + 1),
  localparam int IDX_W      = $clog2(NUM_THR + 1),
  localparam int WORDS      = NUM_CH / CH_PER_WORD,
  localparam int WORD_W     = CH_PER_WORD * CODE_W,
  localparam int WIDX_W     = $clog2(WORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       xing_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
  input  logic                       thr_we_i,
  input  logic [IDX_W-1:0]           thr_idx_i,
  input  logic [SAMPLE_W-1:0]        thr_val_i,
  output logic [WORD_W-1:0]          link_word_o,
  output logic                       link_valid_o,
  output logic                       frame_start_o
);
  logic [NUM_THR*SAMPLE_W-1:0] thr_w;
  logic [NUM_CH*SAMPLE_W-1:0]  peak_w;
  logic [NUM_CH*CODE_W-1:0]    codes_w;
  logic [WIDX_W-1:0]           word_idx_w;

  trip_thr_bank #(.NUM_THR(NUM_THR), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .we_i(thr_we_i), .idx_i(thr_idx_i),
    .val_i(thr_val_i), .thr_flat_o(thr_w));

  trip_peak_hold #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .sample_i(sample_i),
    .peak_o(peak_w));

  trip_code_latch #(.NUM_CH(NUM_CH), .NUM_THR(NUM_THR), .SAMPLE_W(SAMPLE_W),
                    .CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .peak_i(peak_w),
    .thr_i(thr_w), .codes_o(codes_w));

  trip_word_framer #(.NUM_CH(NUM_CH), .CODE_W(CODE_W),
                     .CH_PER_WORD(CH_PER_WORD)) u_frm (
    .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .codes_i(codes_w),
    .word_o(link_word_o), .valid_o(link_valid_o), .start_o(frame_start_o),
    .idx_o(word_idx_w));
endmodule

// File: rtl/trip_encoder_chk.sv
module trip_encoder_chk #(
  parameter int NUM_CH = 24,
  parameter int CODE_W = 3,
  parameter int WORD_W = 12,
  parameter int WORDS  = 6,
  parameter int WIDX_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     xing_i,
  input logic [WORD_W-1:0]        link_word_o,
  input logic                     link_valid_o,
  input logic                     frame_start_o,
  input logic [NUM_CH*CODE_W-1:0] codes_w,
  input logic [WIDX_W-1:0]        word_idx_w
);
  assert_start_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> link_valid_o);

  assert_strobe_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xing_i |=> frame_start_o);

  assert_start_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> $past(xing_i));

  assert_codes_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xing_i |=> $stable(codes_w));

  assert_word0_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> link_word_o == codes_w[WORD_W-1:0]);

  assert_contiguous_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid_o && !frame_start_o) |-> $past(link_valid_o));

  assert_frame_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid_o && int'(word_idx_w) == WORDS - 1 && !xing_i) |=> !link_valid_o);

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !link_valid_o |-> link_word_o == '0);
endmodule

bind trip_encoder trip_encoder_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .WORD_W(WORD_W), .WORDS(WORDS), .WIDX_W(WIDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .link_word_o(link_word_o),
  .link_valid_o(link_valid_o), .frame_start_o(frame_start_o),
  .codes_w(codes_w), .word_idx_w(word_idx_w));

// File: tb/trip_encoder_bench.sv
module trip_encoder_bench;
  localparam int NCH = 24;
  localparam int NT  = 7;
  localparam int SW  = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            xing_i = 1'b0;
  logic [NCH*SW-1:0] sample_i = '0;
  logic            thr_we_i = 1'b0;
  logic [2:0]      thr_idx_i = '0;
  logic [SW-1:0]   thr_val_i = '0;
  logic [11:0]     link_word_o;
  logic            link_valid_o;
  logic            frame_start_o;

  trip_encoder u_trip_encoder (
    .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .sample_i(sample_i),
    .thr_we_i(thr_we_i), .thr_idx_i(thr_idx_i), .thr_val_i(thr_val_i),
    .link_word_o(link_word_o), .link_valid_o(link_valid_o),
    .frame_start_o(frame_start_o));

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int thr_m [NT];
  int samp  [NCH];
  int peak_m[NCH];
  int code_m[NCH];
  int word_m = 0;
  bit act_m  = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int grade(input int p);
    int g = 0;
    for (int t = 0; t < NT; t++) if (p > thr_m[t]) g++;
    return g;
  endfunction

  function automatic int pack_word(input int k);
    int w = 0;
    for (int j = 0; j < 4; j++) w |= code_m[4*k+j] << (3*j);
    return w;
  endfunction

  // one clock: drive at falling edge, update model at rising edge, check at next falling edge
  task automatic step(input bit xs, input bit we = 0, input int widx = 0, input int wval = 0);
    xing_i    = xs;
    thr_we_i  = we;
    thr_idx_i = 3'(widx);
    thr_val_i = SW'(wval);
    for (int c = 0; c < NCH; c++) sample_i[c*SW +: SW] = SW'(samp[c]);
    @(posedge clk);
    if (xs) begin
      for (int c = 0; c < NCH; c++) begin
        code_m[c] = grade(peak_m[c]);
        peak_m[c] = samp[c];
      end
      word_m = 0; act_m = 1;
    end else begin
      for (int c = 0; c < NCH; c++) if (samp[c] > peak_m[c]) peak_m[c] = samp[c];
      if (act_m) begin
        if (word_m == 5) begin act_m = 0; word_m = 0; end
        else word_m++;
      end
    end
    if (we && widx < NT) thr_m[widx] = wval;
    @(negedge clk);
    check("R6 valid", int'(link_valid_o), int'(act_m));
    check("R4 frame_start", int'(frame_start_o), int'(act_m && word_m == 0));
    check("R5 R2 R3 R7 word", int'(link_word_o), act_m ? pack_word(word_m) : 0);
  endtask

  function automatic int pat(input int n, input int cyc, input int ch);
    int tgt = ((ch + n) % 8) * 100 + 50;
    return (cyc == ch % 6) ? tgt : tgt - 10 - cyc;
  endfunction

  task automatic crossing(input int n, input int len);
    for (int cyc = 0; cyc < len; cyc++) begin
      for (int c = 0; c < NCH; c++) samp[c] = pat(n, cyc, c);
      step(cyc == 0);
    end
  endtask

  task automatic flat_crossing(input int v, input int len);
    for (int c = 0; c < NCH; c++) samp[c] = v;
    for (int cyc = 0; cyc < len; cyc++) step(cyc == 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) thr_m[t] = 12'hFFF;
    for (int c = 0; c < NCH; c++) begin samp[c] = 0; peak_m[c] = 0; code_m[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset valid", int'(link_valid_o), 0);
    check("R1 reset start", int'(frame_start_o), 0);
    check("R1 reset word", int'(link_word_o), 0);

    // full-scale samples against reset levels: all codes zero
    flat_crossing(12'hFFF, 6);
    flat_crossing(12'hFFF, 1);
    check("R1 unprogrammed word0", int'(link_word_o), 0);
    flat_crossing(12'hFFF, 5);

    // program ascending levels 100..700; index 7 write must be ignored
    for (int t = 0; t < NT; t++) step(0, 1, t, 100 * (t + 1));
    step(0, 1, 7, 0);

    for (int n = 1; n <= 9; n++) crossing(n, 6);

    // level boundary: peak equal to a level does not count it
    flat_crossing(300, 6);
    flat_crossing(12'hFFF, 1);
    check("R2 equal-to-level word0", int'(link_word_o), 12'o2222);
    for (int cyc = 1; cyc < 6; cyc++) step(0);
    flat_crossing(0, 1);
    check("R2 full-scale word0", int'(link_word_o), 12'o7777);
    for (int cyc = 1; cyc < 6; cyc++) step(0);
    flat_crossing(301, 1);
    check("R2 zero word0", int'(link_word_o), 0);
    for (int cyc = 1; cyc < 6; cyc++) step(0);
    flat_crossing(250, 1);
    check("R2 above-level word0", int'(link_word_o), 12'o3333);

    // R8 early strobes, R6 gap after the frame
    crossing(3, 3);
    crossing(4, 2);
    crossing(5, 9);
    check("R6 idle after frame", int'(link_valid_o), 0);
    crossing(6, 6);

    // R9 write in the strobe cycle grades with the old level
    for (int c = 0; c < NCH; c++) samp[c] = pat(7, 0, c);
    step(1, 1, 3, 12'hFFF);
    for (int cyc = 1; cyc < 6; cyc++) begin
      for (int c = 0; c < NCH; c++) samp[c] = pat(7, cyc, c);
      step(0);
    end
    crossing(8, 6);
    crossing(9, 6);
    step(0, 1, 7, 12'h000);
    crossing(10, 6);
    crossing(11, 7);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule